// File: doc/BRIEF.md
# Scaled-Modulus Long Remainder Unit

This block reduces a long unsigned value of `L` digits, each `W` bits wide, modulo an `N`-digit modulus `m`. Alongside `m` it takes a scaled copy `ms`, a multiple of `m` that is `N+1` digits long and whose top digit is all ones. With that shape, the quotient digit for each reduction step is simply the current top remainder digit. No reciprocal and no multiply are needed to estimate it. At most one extra subtraction of `ms` repairs the rare step where that estimate is one too small.

The value is consumed most significant digit first. The remainder starts as the top `N+1` value digits. Each later value digit is shifted in, and a quotient multiple of `ms` is subtracted digit-serially through one shared digit multiply-add slice that carries a signed carry. Once all digits are consumed, one more subtraction of `ms` leaves a signed remainder whose magnitude is below `m·2^(W+1)`. `W+1` non-restoring passes against `m`, shifted by `W` down to 0 bits, then bring it into `[-m, m)`. A final addition of `m`, made only when the result is negative, leaves `0 <= rem < m`. Computing the scale factor and `ms` is left to the caller.

Top module: `modred_top`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o` and `done_o` are 0 and `rem_o` is 0.
- R2: `start_i` sampled high while idle loads the operands and raises `busy_o` from the next cycle. `busy_o` then stays high up to and including the `done_o` cycle and is low in the cycle after it.
- R3: In the `done_o` cycle, `rem_o` equals `value_i mod mod_i` and is below `mod_i`. This holds when `mod_i` has the top bit of its top digit set, `mod_scaled_i` is a multiple of `mod_i` with top digit all ones, and all three inputs are held stable while `busy_o` is high.
- R4: Each main step uses as its quotient digit the top remainder digit (index N+1 of the shifted value). After that step, remainder digit N+1 is 0 or 1. When it is 1, exactly one extra `ms` subtraction follows, and it clears that digit.
- R5: A run takes P passes of N+3 cycles each. P = (L-N-1) main steps + extra subtractions + 1 trailing `ms` subtraction + (W+1) non-restoring passes + 1 if the result is still negative. `done_o` is high exactly (N+3)·P+1 cycles after the edge that sampled `start_i`.
- R6: `start_i` asserted while `busy_o` is high has no effect on the result or on the timing of `done_o`.
- R7: `done_o` is a single-cycle pulse. `rem_o` holds the result while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reduction when idle |
| value_i | input | L*W | Value to reduce, digit 0 in the low bits |
| mod_i | input | N*W | Modulus m, normalized |
| mod_scaled_i | input | (N+1)*W | Scaled modulus ms, top digit all ones |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| rem_o | output | N*W | Remainder digits |

## Verification
Moduli are taken at both ends of the normalized range (exactly half the digit range and all ones) and at irregular values in between. This exercises both the largest scale factor and a scale factor just above one digit. The values include zero, all ones, `m-1`, `m`, and an exact multiple of `m`. They separate a missed final correction, a missed trailing subtraction, and off-by-one remainders at zero. Mixed 64-bit patterns make the extra `ms` subtraction and the negative-end addition occur in some runs and not in others. Because pass counts then differ, comparing `busy_o` and `done_o` on every cycle against the behavioural pass count tells whether each repair step fired when the arithmetic called for it. One run asserts `start_i` in mid-run to show it is ignored.

// File: rtl/modred_pkg.sv
package modred_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_PASS, ST_DONE} state_e;
  typedef enum logic [2:0] {K_NONE, K_STEP, K_FIX, K_TRIM, K_DIV, K_ADJ} kind_e;
endpackage

// File: rtl/modred_digit_alu.sv
// One digit of R <- src +/- q*opd with a signed carry kept between cycles.
module modred_digit_alu #(
  parameter int W  = 8,
  parameter int QW = W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          first_i,
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  opd_i,
  input  logic [QW-1:0] q_i,
  input  logic          add_i,
  output logic [W-1:0]  dig_o
);
  localparam int PW = W + QW;
  localparam int VW = PW + 3;
  localparam int CW = VW - W;

  logic [PW-1:0] prod;
  logic [VW-1:0] sum;
  logic [CW-1:0] carry_q;
  logic [CW-1:0] cin;

  always_comb begin
    prod = PW'(q_i) * PW'(opd_i);
    cin  = first_i ? '0 : carry_q;
    sum  = VW'(src_i) + {{W{cin[CW-1]}}, cin};
    sum  = add_i ? sum + VW'(prod) : sum - VW'(prod);
  end

  assign dig_o = sum[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   carry_q <= '0;
    else if (en_i) carry_q <= sum[VW-1:W];
  end
endmodule

// File: rtl/modred_rem_store.sv
// Remainder digits 0..N+1 (two's complement across all of them) and the shift-hold digit.
module modred_rem_store #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int IW = $clog2(N + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [(N+1)*W-1:0] load_dig_i,
  input  logic               wr_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [W-1:0]       wdig_i,
  output logic [W-1:0]       rd_o,
  output logic [W-1:0]       hold_o,
  output logic [W-1:0]       top_o,
  output logic [W-1:0]       hi_o,
  output logic [N*W-1:0]     rem_o
);
  localparam int DN = N + 2;

  logic [W-1:0] r_q [DN];
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DN; j++) r_q[j] <= '0;
      hold_q <= '0;
    end else if (load_i) begin
      for (int j = 0; j <= N; j++) r_q[j] <= load_dig_i[j*W +: W];
      r_q[N+1] <= '0;
    end else if (wr_i) begin
      r_q[idx_i] <= wdig_i;
      hold_q     <= r_q[idx_i];
    end
  end

  assign rd_o   = r_q[idx_i];
  assign hold_o = hold_q;
  assign top_o  = r_q[N];
  assign hi_o   = r_q[N+1];

  for (genvar g = 0; g < N; g++) begin : g_rem
    assign rem_o[g*W +: W] = r_q[g];
  end
endmodule

// File: rtl/modred_ctrl.sv
module modred_ctrl
  import modred_pkg::*;
#(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int L  = 8,
  parameter int IW = $clog2(N + 2),
  parameter int XW = $clog2(L),
  parameter int QW = W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  top_i,
  input  logic [W-1:0]  hi_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          run_o,
  output logic          first_o,
  output logic [IW-1:0] idx_o,
  output logic [QW-1:0] q_o,
  output logic          add_o,
  output logic          sel_m_o,
  output logic          shift_o,
  output logic [XW-1:0] xidx_o,
  output logic          pick_o,
  output kind_e         kind_o
);
  localparam int MW = $clog2(L + 1);
  localparam int DW = $clog2(W + 2);
  localparam logic [MW-1:0] MAIN_INIT = MW'(L - N - 1);
  localparam logic [DW-1:0] DIV_INIT  = DW'(W + 1);
  localparam logic [IW-1:0] LAST      = IW'(N + 1);

  state_e        state_q;
  kind_e         kind_q;
  logic [IW-1:0] idx_q;
  logic [MW-1:0] main_left_q;
  logic [DW-1:0] div_left_q;
  logic          trim_done_q;
  logic [QW-1:0] q_q;
  logic          add_q, selm_q, shift_q;
  logic [XW-1:0] xidx_q;
  logic          ovf, neg;

  assign ovf = (hi_i != '0);
  assign neg = hi_i[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_NONE;
      idx_q       <= '0;
      main_left_q <= '0;
      div_left_q  <= '0;
      trim_done_q <= 1'b0;
      q_q         <= '0;
      add_q       <= 1'b0;
      selm_q      <= 1'b0;
      shift_q     <= 1'b0;
      xidx_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          main_left_q <= MAIN_INIT;
          div_left_q  <= DIV_INIT;
          trim_done_q <= 1'b0;
          kind_q      <= K_NONE;
          state_q     <= ST_PICK;
        end
        ST_PICK: begin
          idx_q   <= '0;
          state_q <= ST_PASS;
          q_q     <= QW'(1);
          add_q   <= 1'b0;
          selm_q  <= 1'b0;
          shift_q <= 1'b0;
          if (!trim_done_q && ovf) begin
            kind_q <= K_FIX;
          end else if (main_left_q != '0) begin
            // quotient digit is the top digit of the shifted remainder
            kind_q      <= K_STEP;
            q_q         <= QW'(top_i);
            shift_q     <= 1'b1;
            xidx_q      <= XW'(main_left_q - 1'b1);
            main_left_q <= main_left_q - 1'b1;
          end else if (!trim_done_q) begin
            kind_q      <= K_TRIM;
            trim_done_q <= 1'b1;
          end else if (div_left_q != '0) begin
            kind_q     <= K_DIV;
            q_q        <= QW'(1) << (div_left_q - 1'b1);
            add_q      <= neg;
            selm_q     <= 1'b1;
            div_left_q <= div_left_q - 1'b1;
          end else if (neg) begin
            kind_q <= K_ADJ;
            add_q  <= 1'b1;
            selm_q <= 1'b1;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_PASS: begin
          if (idx_q == LAST) begin
            idx_q   <= '0;
            state_q <= ST_PICK;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign run_o   = (state_q == ST_PASS);
  assign first_o = (idx_q == '0);
  assign pick_o  = (state_q == ST_PICK);
  assign idx_o   = idx_q;
  assign q_o     = q_q;
  assign add_o   = add_q;
  assign sel_m_o = selm_q;
  assign shift_o = shift_q;
  assign xidx_o  = xidx_q;
  assign kind_o  = kind_q;
endmodule

// File: rtl/modred_top.sv
module modred_top
  import modred_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 4,
  parameter int L = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [L*W-1:0]     value_i,
  input  logic [N*W-1:0]     mod_i,
  input  logic [(N+1)*W-1:0] mod_scaled_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [N*W-1:0]     rem_o
);
  localparam int IW = $clog2(N + 2);
  localparam int XW = $clog2(L);
  localparam int QW = W + 1;
  localparam int DN = N + 2;

  logic [W-1:0] val_d [L];
  logic [W-1:0] m_d   [DN];
  logic [W-1:0] ms_d  [DN];

  for (genvar g = 0; g < L; g++) begin : g_val
    assign val_d[g] = value_i[g*W +: W];
  end
  for (genvar g = 0; g < DN; g++) begin : g_mod
    if (g < N) begin : g_m
      assign m_d[g] = mod_i[g*W +: W];
    end else begin : g_mz
      assign m_d[g] = '0;
    end
    if (g <= N) begin : g_s
      assign ms_d[g] = mod_scaled_i[g*W +: W];
    end else begin : g_sz
      assign ms_d[g] = '0;
    end
  end

  logic          load, run, first, add, sel_m, shift, pick;
  logic [IW-1:0] idx;
  logic [XW-1:0] xidx;
  logic [QW-1:0] q;
  kind_e         kind;
  logic [W-1:0]  rd_dig, hold_dig, top_dig, hi_dig, wdig, src_dig, opd_dig;

  modred_ctrl #(.W(W), .N(N), .L(L), .IW(IW), .XW(XW), .QW(QW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .top_i   (top_dig),
    .hi_i    (hi_dig),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .run_o   (run),
    .first_o (first),
    .idx_o   (idx),
    .q_o     (q),
    .add_o   (add),
    .sel_m_o (sel_m),
    .shift_o (shift),
    .xidx_o  (xidx),
    .pick_o  (pick),
    .kind_o  (kind)
  );

  // main step works on R*d + x: digit 0 is the incoming value digit
  assign src_dig = shift ? ((idx == '0) ? val_d[xidx] : hold_dig) : rd_dig;
  assign opd_dig = sel_m ? m_d[idx] : ms_d[idx];

  modred_digit_alu #(.W(W), .QW(QW)) u_alu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (run),
    .first_i (first),
    .src_i   (src_dig),
    .opd_i   (opd_dig),
    .q_i     (q),
    .add_i   (add),
    .dig_o   (wdig)
  );

  modred_rem_store #(.W(W), .N(N), .IW(IW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_dig_i (value_i[L*W-1 -: (N+1)*W]),
    .wr_i       (run),
    .idx_i      (idx),
    .wdig_i     (wdig),
    .rd_o       (rd_dig),
    .hold_o     (hold_dig),
    .top_o      (top_dig),
    .hi_o       (hi_dig),
    .rem_o      (rem_o)
  );
endmodule

// File: rtl/modred_chk.sv
module modred_chk
  import modred_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_i,
  input logic           done_i,
  input logic [N*W-1:0] rem_i,
  input logic [N*W-1:0] mod_i,
  input logic           pick_i,
  input kind_e          kind_i,
  input logic [W-1:0]   hi_i
);
  // R3
  rem_below_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (rem_i < mod_i));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i);
  // R4
  fix_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_i && kind_i == K_FIX) |-> (hi_i == '0));
  // R4
  step_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_i && kind_i == K_STEP) |-> (hi_i <= W'(1)));
  // R7
  rem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(rem_i));
endmodule

bind modred_top modred_chk #(.W(W), .N(N)) u_modred_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .rem_i   (rem_o),
  .mod_i   (mod_i),
  .pick_i  (pick),
  .kind_i  (kind),
  .hi_i    (hi_dig)
);

// File: tb/modred_top_bench.sv
module modred_top_bench;
  localparam int W = 8;
  localparam int N = 4;
  localparam int L = 8;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [L*W-1:0]     value_i = '0;
  logic [N*W-1:0]     mod_i = '0;
  logic [(N+1)*W-1:0] mod_scaled_i = '0;
  logic               busy_o, done_o;
  logic [N*W-1:0]     rem_o;

  int checks = 0;
  int errors = 0;

  modred_top #(.W(W), .N(N), .L(L)) u_modred_top (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .value_i(value_i),
    .mod_i(mod_i), .mod_scaled_i(mod_scaled_i),
    .busy_o(busy_o), .done_o(done_o), .rem_o(rem_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural pass count from the requirement arithmetic (R4, R5)
  function automatic int model_passes(input logic [63:0] v, input longint m, input longint ms);
    longint r, t, q, x;
    int p = 0;
    r = longint'(v >> (W*(L-N-1)));
    for (int k = L-N-2; k >= 0; k--) begin
      x = longint'((v >> (W*k)) & 64'hFF);
      t = r * 256 + x;
      q = t >>> (W*(N+1));
      r = t - q * ms;
      p++;
      if (r >= (longint'(1) << (W*(N+1)))) begin
        r = r - ms;
        p++;
      end
    end
    r = r - ms;
    p++;
    for (int k = W; k >= 0; k--) begin
      if (r < 0) r = r + (m << k);
      else       r = r - (m << k);
      p++;
    end
    if (r < 0) p++;
    return p;
  endfunction

  task automatic run_case(input logic [63:0] v, input logic [31:0] m, input int poke);
    longint ml, s, ms;
    logic [63:0] exp_rem;
    int p, lat;
    ml = longint'(m);
    s  = ((longint'(255) << 32) + ml - 1) / ml;
    ms = ml * s;
    exp_rem = v % {32'b0, m};
    p   = model_passes(v, ml, ms);
    lat = p * (N + 3) + 1;
    @(negedge clk);
    value_i = v; mod_i = m; mod_scaled_i = 40'(ms); start_i = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= lat; c++) begin
      @(negedge clk);
      start_i = (c == poke);
      check(busy_o == 1'b1, "R2 R6", "busy during run", 64'(busy_o), 64'd1);
      check(done_o == (c == lat), "R5 R4 R7", "done timing", 64'(done_o), 64'(c == lat));
      if (c == lat)
        check(64'(rem_o) == exp_rem, "R3", "remainder", 64'(rem_o), exp_rem);
    end
    start_i = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R2", "idle after done", 64'(busy_o), 64'd0);
    check(done_o == 1'b0, "R7", "done pulse width", 64'(done_o), 64'd0);
    repeat (3) @(negedge clk);
    check(64'(rem_o) == exp_rem, "R7", "remainder held", 64'(rem_o), exp_rem);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags in reset",
          {62'b0, busy_o, done_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "flags after reset",
          {62'b0, busy_o, done_o}, 64'd0);
    check(rem_o == '0, "R1", "remainder after reset", 64'(rem_o), 64'd0);

    run_case(64'h0, 32'h8000_0000, -1);
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000, -1);
    run_case(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, -1);
    run_case(64'h0000_0000_FFFF_FFFE, 32'hFFFF_FFFF, -1);
    run_case(64'h0000_0000_9E37_79B9, 32'h9E37_79B9, -1);
    run_case(64'h9E37_79B9 * 64'd12345, 32'h9E37_79B9, -1);
    run_case(64'h0123_4567_89AB_CDEF, 32'hDEAD_BEEF, -1);
    run_case(64'hFEDC_BA98_7654_3210, 32'hC000_0001, -1);
    run_case(64'h8000_0000_0000_0001, 32'hC000_0001, -1);
    run_case(64'h7FFF_FFFF_0000_0000, 32'hB504_F333, 5);
    run_case(64'hDEAD_BEEF_CAFE_F00D, 32'h8765_4321, -1);
    run_case(64'h00FF_00FF_00FF_00FF, 32'hFFFF_FFFE, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule